// File: doc/BRIEF.md
# Pixel Clock PLL Parameter Search

This block picks the settings for a pixel clock built from a 3 MHz reference. The reference is multiplied by N, optionally doubled, and then divided by M. Given a requested dot clock in kHz, the block finds the N, M and doubler setting whose output equals the request or, failing that, comes closest to it from below. Display sinks tend not to lock to a clock that is too fast, which is why the result never exceeds the request.

A request is a one-cycle `start` with the target and a channel select. The channel select chooses the allowed range of M. The engine then walks M upward one value at a time. It computes each candidate with a shared restoring divider: one division gives N and a second gives the frequency that N would produce. When the scan ends, the block presents N, M, the doubler flag, the base PLL frequency and a one-cycle `done`. A `no_sol` flag is raised instead when no candidate qualifies.

Top module: `pclk_pll_search`

## Requirements
- R1: With `chan_sel`=0, M ranges over 6..127. With `chan_sel`=1, M ranges over 1..15. M is scanned in ascending order.
- R2: For each M, the plain candidate uses N = floor(M*T/3000) and yields floor(3000*N/M) kHz. The doubled candidate uses 6000 in place of 3000. T is `target_khz`.
- R3: A candidate counts only when its N lies in 9..127 inclusive.
- R4: The doubled candidate is evaluated only for odd M. `dbl_en`=1 therefore always comes with an odd `post_m`.
- R5: The reported setting has the smallest error T minus output, and its output never exceeds T.
- R6: A candidate replaces the held best only when its error is strictly smaller. On equal error, the lower M wins, and at the same M the plain candidate wins over the doubled one.
- R7: When no candidate qualifies, `no_sol`=1 and `pll_n`, `post_m` and `dbl_en` are all 0.
- R8: `done` is high for exactly one cycle per accepted request. The result outputs hold their values until the next `done`.
- R9: A `start` that arrives while `busy`=1 is ignored: it produces no extra `done` and does not alter the running search.
- R10: After a synchronous active-low reset, `busy`, `done`, `no_sol`, `dbl_en`, `pll_n`, `post_m` and `pll_base_khz` are all 0.
- R11: `pll_base_khz` equals `pll_n`*3000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| chan_sel | input | 1 | Selects the M range (0: 6..127, 1: 1..15) |
| target_khz | input | 20 | Requested dot clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| no_sol | output | 1 | No qualifying candidate was found |
| pll_n | output | 7 | Selected multiplier N |
| post_m | output | 7 | Selected divider M |
| dbl_en | output | 1 | Doubler selected |
| pll_base_khz | output | 19 | Base PLL frequency N*3000 kHz |

## Verification
The assertions check the following at every `done`:
- the divider identity quotient*divisor+remainder=dividend;
- that the held best error never rises during a scan;
- that M lies inside the channel's range and N inside 9..127;
- that the doubler appears only with odd M;
- that the chosen output is not above the target;
- the zeroed outputs on no solution;
- the single-cycle width of `done`.

Some behaviour can only be shown by the bench's scenarios against hand-derived results. These cover whether the chosen setting is truly the closest one, the tie order between equal M and between the plain and doubled paths, the channel-specific range edges, the exact N=127/128 boundary, and requests ignored while busy.

// File: rtl/pclk_srch_pkg.sv
// Package: constants and state type shared by the PLL parameter search.
// Assumes N and M both fit in 7 bits and divisors in 13 bits.
package pclk_srch_pkg;
    localparam int unsigned NM_W     = 7;
    localparam int unsigned DEN_W    = 13;
    localparam int unsigned BASE_KHZ = 3000;
    localparam int unsigned N_LO     = 9;
    localparam int unsigned N_HI     = 127;

    typedef enum logic [2:0] {
        ST_IDLE, ST_NDIV, ST_NWAIT, ST_VDIV, ST_VWAIT, ST_STEP, ST_FIN
    } srch_state_t;
endpackage

// File: rtl/pclk_srch_div.sv
// Restoring divider with a fixed latency: one bit per cycle, NUM_W cycles.
// Assumes den is non-zero. quot/rem are valid while done is high.
module pclk_srch_div #(
    parameter int unsigned NUM_W = 27,
    parameter int unsigned DEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int unsigned CW = $clog2(NUM_W);
    localparam logic [CW-1:0] LAST = CW'(NUM_W - 1);

    logic [NUM_W-1:0] q_r, num_r;
    logic [DEN_W-1:0] r_r, d_r;
    logic [CW-1:0]    cnt;
    logic             run;
    logic [DEN_W:0]   shifted;
    logic             fits;

    // Partial remainder after shifting in the next dividend bit.
    always_comb begin
        shifted = {r_r, q_r[NUM_W-1]};
        fits    = (shifted >= {1'b0, d_r});
    end

    // Iteration register: load on start, one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0; r_r <= '0; d_r <= '0; num_r <= '0;
            cnt <= '0; run <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r <= num; r_r <= '0; d_r <= den; num_r <= num;
                cnt <= '0; run <= 1'b1;
            end else if (run) begin
                r_r <= fits ? DEN_W'(shifted - {1'b0, d_r}) : shifted[DEN_W-1:0];
                q_r <= {q_r[NUM_W-2:0], fits};
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((NUM_W+DEN_W)'(q_r) * (NUM_W+DEN_W)'(d_r) + (NUM_W+DEN_W)'(r_r)
                  == (NUM_W+DEN_W)'(num_r)) && (r_r < d_r)); // R2
endmodule

// File: rtl/pclk_srch_best.sv
// Best-candidate register: keeps the lowest error seen since clr.
// Assumes candidates arrive in scan order; strict compare makes earlier win ties.
module pclk_srch_best
    import pclk_srch_pkg::*;
#(
    parameter int unsigned ERR_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cand_vld,
    input  logic [ERR_W-1:0] cand_err,
    input  logic [NM_W-1:0]  cand_n,
    input  logic [NM_W-1:0]  cand_m,
    input  logic             cand_dbl,
    output logic             has_best,
    output logic [NM_W-1:0]  best_n,
    output logic [NM_W-1:0]  best_m,
    output logic             best_dbl
);
    logic [ERR_W-1:0] best_err;

    // Replace the held winner only on a strictly smaller error.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_err <= '1; has_best <= 1'b0;
            best_n <= '0; best_m <= '0; best_dbl <= 1'b0;
        end else if (cand_vld && cand_err < best_err) begin
            best_err <= cand_err; has_best <= 1'b1;
            best_n <= cand_n; best_m <= cand_m; best_dbl <= cand_dbl;
        end
    end

    AST_ERR_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_err <= $past(best_err)); // R6
endmodule

// File: rtl/pclk_pll_search.sv
// Top: scans M over the channel's range, tries the plain and (odd M) doubled
// candidates through one shared divider, and reports the closest setting
// not above the target. Requests are taken only while idle.
module pclk_pll_search
    import pclk_srch_pkg::*;
#(
    parameter int unsigned TGT_W  = 20,
    parameter int unsigned CH0_LO = 6,
    parameter int unsigned CH0_HI = 127,
    parameter int unsigned CH1_LO = 1,
    parameter int unsigned CH1_HI = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             chan_sel,
    input  logic [TGT_W-1:0] target_khz,
    output logic             busy,
    output logic             done,
    output logic             no_sol,
    output logic [6:0]       pll_n,
    output logic [6:0]       post_m,
    output logic             dbl_en,
    output logic [18:0]      pll_base_khz
);
    localparam int unsigned NUM_W = TGT_W + NM_W;

    srch_state_t      state;
    logic [TGT_W-1:0] tgt_q;
    logic             chan_q;
    logic [NM_W-1:0]  m_cur, m_hi, n_cand;
    logic             dbl_cur;
    logic             div_start, div_done;
    logic [NUM_W-1:0] div_num, div_quot;
    logic [DEN_W-1:0] div_den, base_sel;
    logic             has_best, best_dbl;
    logic [NM_W-1:0]  best_n, best_m;

    // Reference multiple for the current path: 3000 plain, 6000 doubled.
    assign base_sel  = dbl_cur ? DEN_W'(2*BASE_KHZ) : DEN_W'(BASE_KHZ);
    assign div_start = (state == ST_NDIV) || (state == ST_VDIV);

    // Operand mux: N division first, then the resulting-frequency division.
    always_comb begin
        if (state == ST_VDIV) begin
            div_num = NUM_W'(base_sel) * NUM_W'(n_cand);
            div_den = DEN_W'(m_cur);
        end else begin
            div_num = NUM_W'(m_cur) * NUM_W'(tgt_q);
            div_den = base_sel;
        end
    end

    pclk_srch_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quot(div_quot)
    );

    pclk_srch_best #(.ERR_W(NUM_W)) u_best (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_IDLE && start),
        .cand_vld(state == ST_VWAIT && div_done),
        .cand_err(NUM_W'(tgt_q) - div_quot),
        .cand_n(n_cand), .cand_m(m_cur), .cand_dbl(dbl_cur),
        .has_best(has_best), .best_n(best_n), .best_m(best_m), .best_dbl(best_dbl)
    );

    // Sequencer: walks M upward, odd M gets a second (doubled) pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; tgt_q <= '0; chan_q <= 1'b0;
            m_cur <= '0; m_hi <= '0; n_cand <= '0; dbl_cur <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    tgt_q   <= target_khz;
                    chan_q  <= chan_sel;
                    m_cur   <= chan_sel ? NM_W'(CH1_LO) : NM_W'(CH0_LO);
                    m_hi    <= chan_sel ? NM_W'(CH1_HI) : NM_W'(CH0_HI);
                    dbl_cur <= 1'b0;
                    state   <= ST_NDIV;
                end
                ST_NDIV:  state <= ST_NWAIT;
                ST_NWAIT: if (div_done) begin
                    n_cand <= div_quot[NM_W-1:0];
                    state  <= (div_quot >= NUM_W'(N_LO) && div_quot <= NUM_W'(N_HI))
                              ? ST_VDIV : ST_STEP;
                end
                ST_VDIV:  state <= ST_VWAIT;
                ST_VWAIT: if (div_done) state <= ST_STEP;
                ST_STEP: begin
                    if (!dbl_cur && m_cur[0]) begin
                        dbl_cur <= 1'b1;
                        state   <= ST_NDIV;
                    end else if (m_cur == m_hi) begin
                        state <= ST_FIN;
                    end else begin
                        m_cur   <= m_cur + 1'b1;
                        dbl_cur <= 1'b0;
                        state   <= ST_NDIV;
                    end
                end
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Result registers: loaded once per scan, held until the next scan ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; no_sol <= 1'b0; pll_n <= '0; post_m <= '0;
            dbl_en <= 1'b0; pll_base_khz <= '0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                no_sol       <= !has_best;
                pll_n        <= has_best ? best_n : '0;
                post_m       <= has_best ? best_m : '0;
                dbl_en       <= has_best && best_dbl;
                pll_base_khz <= has_best ? 19'(best_n) * 19'(BASE_KHZ) : '0;
            end
        end
    end

    assign busy = (state != ST_IDLE);

    AST_M_IN_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (chan_q ? (post_m >= NM_W'(CH1_LO) && post_m <= NM_W'(CH1_HI))
                                      : (post_m >= NM_W'(CH0_LO) && post_m <= NM_W'(CH0_HI)))); // R1
    AST_N_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (pll_n >= 7'(N_LO) && pll_n <= 7'(N_HI))); // R3
    AST_DBL_ODD_M: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbl_en) |-> post_m[0]); // R4
    AST_NOT_ABOVE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> (NUM_W'(pll_n) * NUM_W'(dbl_en ? 2*BASE_KHZ : BASE_KHZ)
                               <= NUM_W'(post_m) * NUM_W'(tgt_q))); // R5
    AST_NOSOL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_sol) |-> (pll_n == '0 && post_m == '0 && !dbl_en)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_KEEPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_q) && $stable(chan_q)); // R9
    AST_BASE_MATCHES_N: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pll_base_khz == 19'(pll_n) * 19'(BASE_KHZ)); // R11
endmodule

// File: tb/pclk_pll_search_bench.sv
module pclk_pll_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        chan_sel = 1'b0;
    logic [19:0] target_khz = '0;
    logic        busy, done, no_sol, dbl_en;
    logic [6:0]  pll_n, post_m;
    logic [18:0] pll_base_khz;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    pclk_pll_search u_pclk_pll_search (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .target_khz(target_khz), .busy(busy), .done(done), .no_sol(no_sol),
        .pll_n(pll_n), .post_m(post_m), .dbl_en(dbl_en), .pll_base_khz(pll_base_khz)
    );

    // Fields: [36] chan, [35:16] target, [15:9] N, [8:2] M, [1] dbl, [0] no_sol
    localparam int NV = 11;
    localparam logic [36:0] VEC [0:NV-1] = '{
        {1'b1, 20'd27000,  7'd9,   7'd1,   1'b0, 1'b0}, // R2 exact at M=1
        {1'b1, 20'd28000,  7'd28,  7'd3,   1'b0, 1'b0}, // R5 better exact at M=3
        {1'b1, 20'd6000,   7'd10,  7'd5,   1'b0, 1'b0}, // R3 N<9 rejected below M=5
        {1'b1, 20'd54000,  7'd18,  7'd1,   1'b0, 1'b0}, // R6 plain beats equal doubled
        {1'b1, 20'd400000, 7'd66,  7'd1,   1'b1, 1'b0}, // R4 only doubled path fits
        {1'b1, 20'd381000, 7'd127, 7'd1,   1'b0, 1'b0}, // R3 N=127 accepted
        {1'b1, 20'd384000, 7'd64,  7'd1,   1'b1, 1'b0}, // R3 N=128 rejected
        {1'b1, 20'd1000,   7'd0,   7'd0,   1'b0, 1'b1}, // R7 no solution
        {1'b0, 20'd27000,  7'd54,  7'd6,   1'b0, 1'b0}, // R1 channel 0 starts at M=6
        {1'b0, 20'd213,    7'd9,   7'd127, 1'b0, 1'b0}, // R1 channel 0 reaches M=127
        {1'b0, 20'd400000, 7'd0,   7'd0,   1'b0, 1'b1}  // R1 R7 no M>=6 fits
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic ch, input logic [19:0] t);
        @(negedge clk);
        start = 1'b1; chan_sel = ch; target_khz = t;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic seen;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 n", pll_n, 0);
        chk("R10 m", post_m, 0);
        chk("R10 base", pll_base_khz, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            issue(VEC[v][36], VEC[v][35:16]);
            chk("R9 busy after start", busy, 1);
            wait_done(seen);
            chk("R8 done seen", seen, 1);
            chk("R2 n", pll_n, int'(VEC[v][15:9]));
            chk("R5 m", post_m, int'(VEC[v][8:2]));
            chk("R4 dbl", dbl_en, int'(VEC[v][1]));
            chk("R7 nosol", no_sol, int'(VEC[v][0]));
            chk("R11 base", pll_base_khz, int'(VEC[v][15:9]) * 3000);
            @(negedge clk);
            chk("R8 done one cycle", done, 0);
        end

        // R8 results held after done
        chk("R8 hold n", pll_n, 0);
        chk("R8 hold nosol", no_sol, 1);

        // R9 start while busy is ignored
        issue(1'b1, 20'd27000);
        repeat (5) @(negedge clk);
        issue(1'b1, 20'd1000);
        wait_done(seen);
        chk("R9 first done", seen, 1);
        chk("R9 n kept", pll_n, 9);
        chk("R9 m kept", post_m, 1);
        chk("R9 nosol kept", no_sol, 0);
        @(negedge clk);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        chk("R9 no second done", seen, 0);
        chk("R9 idle", busy, 0);

        // R10 reset in mid-scan clears everything
        issue(1'b0, 20'd27000);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 busy mid", busy, 0);
        chk("R10 n mid", pll_n, 0);
        chk("R10 m mid", post_m, 0);
        chk("R10 base mid", pll_base_khz, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 tie at the same M after reset: plain path kept
        issue(1'b1, 20'd54000);
        wait_done(seen);
        chk("R6 tie dbl", dbl_en, 0);
        chk("R6 tie n", pll_n, 18);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule